// File: doc/BRIEF.md
# Timer Channel Register Core

One 16-bit timer channel with a small memory-mapped register set. Software picks a counting clock in a mode register. The choices are the system clock divided by 2, 8, 32 or 128, or a slow time base that arrives as a one-cycle enable pulse. Software then drives the channel through a write-only command register that holds run, stop and restart bits. A restart clears the counter. Stopping the channel freezes the count, and running it again continues from the frozen value.

Event flags collect into a status word. The counter's own wrap raises bit 0. Bits 7:1 come from event strobes produced by neighbouring capture and trigger logic. Reading the status word clears these flags. Two write-only registers set and clear an interrupt mask, and a third register reads the mask back. The interrupt line is high while any pending flag has its mask bit set.

Top module: `tcChanCore`

## Requirements
- R1: After reset the count, mode, mask and pending flags are all zero, the channel is stopped and `irq` is low.
- R2: A write to offset 0x00 is a command word. Bit 0 runs the channel, bit 1 stops it and bit 2 restarts the count. When bit 0 and bit 1 are written together, the channel stops.
- R3: A restart sets the count to 0 on the write edge, whether or not the channel is running. Writing bits 0 and 2 together starts counting from zero.
- R4: Mode bits 2:0 at offset 0x04 select the clock. Values 0, 1, 2 and 3 give one count per 2, 8, 32 and 128 clocks, counted from the restart edge, so k clocks after a restart the count is floor(k/div). Value 4 gives one count per clock in which `slowTick` is high. Values 5 to 7 never count.
- R5: While the channel is stopped the count holds, even with ticks present. Running the channel again without a restart continues from the held value.
- R6: A count step from 0xFFFF wraps to 0 and sets status bit 0.
- R7: Status at offset 0x20: bits 7:1 latch the `srcEvent` strobes, where bit 5 is an RA load, bit 6 an RB load and bit 7 an external trigger. A status read clears bits 7:0. Bit 16 shows whether the channel is running, and a read does not clear it.
- R8: A flag whose event arrives in the same cycle as a status read is not returned by that read and remains set after it.
- R9: Writing offset 0x24 sets each mask bit written as 1, and writing 0x28 clears each one. Offset 0x2C reads the mask. Mask bits written as 0 keep their value.
- R10: `irq` is high exactly when some pending flag has its mask bit set.
- R11: The count reads at offset 0x10. Writes to it are ignored, and the command register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; read data is valid in the same cycle |
| regAddr | input | 6 | Byte offset of the register |
| regWrData | input | 8 | Write data |
| regRdData | output | 32 | Read data, zero when no read is active |
| slowTick | input | 1 | Slow time base enable pulse |
| srcEvent | input | 7 | Event strobes for status bits 7:1 |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is the counter wrap. The wrap needs 65536 counts after a restart, and with the fastest divided clock that would take twice as many cycles. The bench selects the slow time base and holds `slowTick` high, so the wrap happens exactly 65536 edges after the restart. It then reads the count in the last cycle before the wrap, and that read's own edge performs the wrap. A second awkward case is an event that coincides with a status read. The bench gets there with a read task that drives the event strobes during the read cycle.

// File: rtl/tcChanPkg.sv
package tcChanPkg;
  localparam int ADDR_W = 6;
  localparam int WR_W   = 8;
  localparam int RD_W   = 32;
  localparam int EVT_W  = 8;
  localparam int SEL_W  = 3;

  localparam logic [ADDR_W-1:0] OFF_CMD   = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_COUNT = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_MSET  = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_MCLR  = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h2C;

  localparam int CMD_RUN  = 0;
  localparam int CMD_STOP = 1;
  localparam int CMD_RST  = 2;
  localparam int STAT_RUN = 16;

  typedef struct packed {
    logic runCmd;
    logic stopCmd;
    logic restart;
  } cmdStrobe_t;
endpackage

// File: rtl/tcCountPath.sv
module tcCountPath
  import tcChanPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  cmdStrobe_t       cmd,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             slowTick,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             wrapPulse
);
  localparam logic [PRE_W-1:0] ONES = {PRE_W{1'b1}};

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             tick;
  logic             stepEn;

  always_comb begin
    preMask = '0;
    tick    = 1'b0;
    case (clkSel)
      3'd0: begin preMask = PRE_W'(1);   tick = ((preCnt | ~preMask) == ONES); end
      3'd1: begin preMask = PRE_W'(7);   tick = ((preCnt | ~preMask) == ONES); end
      3'd2: begin preMask = PRE_W'(31);  tick = ((preCnt | ~preMask) == ONES); end
      3'd3: begin preMask = PRE_W'(127); tick = ((preCnt | ~preMask) == ONES); end
      3'd4: tick = slowTick;
      default: tick = 1'b0;
    endcase
  end

  assign stepEn    = running && tick && !cmd.restart;
  assign wrapPulse = stepEn && (&count);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      count   <= '0;
      running <= 1'b0;
    end else begin
      preCnt <= cmd.restart ? '0 : preCnt + 1'b1;
      if (cmd.restart)   count <= '0;
      else if (stepEn)   count <= count + 1'b1;
      if (cmd.stopCmd)     running <= 1'b0;
      else if (cmd.runCmd) running <= 1'b1;
    end
  end

  p_stop_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stopCmd |=> !running);
  p_run_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.runCmd && !cmd.stopCmd) |=> running);
  p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.restart |=> (count == '0));
  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cmd.restart) |=> $stable(count));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> (count == '0));
endmodule

// File: rtl/tcRegCtrl.sv
module tcRegCtrl
  import tcChanPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WR_W-1:0]   regWrData,
  input  logic [CNT_W-1:0]  count,
  input  logic              running,
  input  logic              wrapPulse,
  input  logic [EVT_W-1:1]  srcEvent,
  output cmdStrobe_t        cmd,
  output logic [SEL_W-1:0]  clkSel,
  output logic [RD_W-1:0]   regRdData,
  output logic              irq
);
  logic             cmdWr, modeWr, setWr, clrWr, statRd;
  logic [EVT_W-1:0] maskReg;
  logic [EVT_W-1:0] pending;
  logic [EVT_W-1:0] newEvt;

  assign cmdWr  = regWrEn && (regAddr == OFF_CMD);
  assign modeWr = regWrEn && (regAddr == OFF_MODE);
  assign setWr  = regWrEn && (regAddr == OFF_MSET);
  assign clrWr  = regWrEn && (regAddr == OFF_MCLR);
  assign statRd = regRdEn && (regAddr == OFF_STAT);

  assign cmd.runCmd  = cmdWr && regWrData[CMD_RUN];
  assign cmd.stopCmd = cmdWr && regWrData[CMD_STOP];
  assign cmd.restart = cmdWr && regWrData[CMD_RST];

  assign newEvt = {srcEvent, wrapPulse};
  assign irq    = |(pending & maskReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel  <= '0;
      maskReg <= '0;
      pending <= '0;
    end else begin
      if (modeWr) clkSel <= regWrData[SEL_W-1:0];
      if (setWr)       maskReg <= maskReg | regWrData[EVT_W-1:0];
      else if (clrWr)  maskReg <= maskReg & ~regWrData[EVT_W-1:0];
      pending <= (statRd ? '0 : pending) | newEvt;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        OFF_MODE:  regRdData[SEL_W-1:0] = clkSel;
        OFF_COUNT: regRdData[CNT_W-1:0] = count;
        OFF_STAT:  begin
          regRdData[EVT_W-1:0] = pending;
          regRdData[STAT_RUN]  = running;
        end
        OFF_MASK:  regRdData[EVT_W-1:0] = maskReg;
        default:   regRdData = '0;
      endcase
    end
  end

  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && newEvt == '0) |=> (pending == '0));
  p_keep_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    (newEvt != '0) |=> ((pending & $past(newEvt)) == $past(newEvt)));
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    setWr |=> ((maskReg & $past(regWrData)) == $past(regWrData)));
  p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((maskReg & $past(regWrData)) == '0));
  p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |-> !irq);
endmodule

// File: rtl/tcChanCore.sv
module tcChanCore
  import tcChanPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WR_W-1:0]   regWrData,
  output logic [RD_W-1:0]   regRdData,
  input  logic              slowTick,
  input  logic [EVT_W-1:1]  srcEvent,
  output logic              irq
);
  cmdStrobe_t       cmd;
  logic [SEL_W-1:0] clkSel;
  logic [CNT_W-1:0] count;
  logic             running;
  logic             wrapPulse;

  tcRegCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .count(count),
    .running(running), .wrapPulse(wrapPulse), .srcEvent(srcEvent),
    .cmd(cmd), .clkSel(clkSel), .regRdData(regRdData), .irq(irq)
  );

  tcCountPath #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .clkSel(clkSel),
    .slowTick(slowTick), .count(count), .running(running),
    .wrapPulse(wrapPulse)
  );
endmodule

// File: tb/tcChanCore_bench.sv
`timescale 1ns/1ps
module tcChanCore_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [31:0] regRdData;
  logic        slowTick = 1'b0;
  logic [7:1]  srcEvent = '0;
  logic        irq;
  int nChk = 0, nFail = 0;
  logic [31:0] d;
  logic [7:0]  mMask, mPend;
  int unsigned expCnt;

  always #5 clk = ~clk;

  tcChanCore u_tcChanCore (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .slowTick(slowTick), .srcEvent(srcEvent), .irq(irq)
  );

  function automatic int unsigned divOf(input int sel);
    case (sel) 0: return 2; 1: return 8; 2: return 32; default: return 128; endcase
  endfunction

  function automatic int unsigned expDiv(input int unsigned k, input int sel);
    return k / divOf(sel);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] v);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:1] ev, output logic [31:0] v);
    regRdEn = 1'b1; regAddr = a; srcEvent = ev;
    #1 v = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0; srcEvent = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulseEvt(input logic [7:1] ev);
    srcEvent = ev; @(posedge clk); @(negedge clk); srcEvent = '0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nFail++; nChk++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(6'h10, '0, d); chk("R1 count", d, 32'h0);
    rd(6'h20, '0, d); chk("R1 status", d, 32'h0);
    rd(6'h2C, '0, d); chk("R1 mask", d, 32'h0);
    rd(6'h04, '0, d); chk("R1 mode", d, 32'h0);
    rd(6'h00, '0, d); chk("R11 command reads zero", d, 32'h0);

    // R4 / R3 divided clocks from restart
    for (int s = 0; s < 4; s++) begin
      int unsigned k;
      k = 40 + ($urandom % 300);
      wr(6'h04, 8'(s));
      wr(6'h00, 8'h05);
      idle(k);
      rd(6'h10, '0, d); chk($sformatf("R4 R3 sel%0d k%0d", s, k), d, expDiv(k, s));
      rd(6'h20, '0, d); chk("R7 run bit set", d & 32'h10000, 32'h10000);
      wr(6'h00, 8'h02);
    end
    wr(6'h04, 8'd6);
    wr(6'h00, 8'h05);
    idle(300);
    rd(6'h10, '0, d); chk("R4 sel6 no counting", d, 32'h0);

    // R2 run and stop together: stop wins
    wr(6'h00, 8'h03);
    rd(6'h20, '0, d); chk("R2 stop wins", d & 32'h10000, 32'h0);

    // R5 hold and resume with the slow base
    wr(6'h04, 8'd4);
    wr(6'h00, 8'h05);
    expCnt = 0;
    for (int i = 0; i < 200; i++) begin
      slowTick = $urandom % 2;
      if (slowTick) expCnt++;
      @(posedge clk); @(negedge clk);
    end
    slowTick = 1'b0;
    rd(6'h10, '0, d); chk("R4 slow base count", d, expCnt);
    wr(6'h00, 8'h02);
    slowTick = 1'b1; idle(25); slowTick = 1'b0;
    rd(6'h10, '0, d); chk("R5 hold while stopped", d, expCnt);
    wr(6'h10, 8'h5A);
    rd(6'h10, '0, d); chk("R11 count write ignored", d, expCnt);
    wr(6'h00, 8'h01);
    slowTick = 1'b1; idle(10); slowTick = 1'b0;
    rd(6'h10, '0, d); chk("R5 resume", d, expCnt + 10);
    wr(6'h00, 8'h02);
    wr(6'h00, 8'h04);
    rd(6'h10, '0, d); chk("R3 restart while stopped", d, 32'h0);
    rd(6'h20, '0, d); chk("R3 stays stopped", d, 32'h0);

    // R7 events and read clear, run bit kept
    wr(6'h00, 8'h01);
    pulseEvt(7'b0010000);
    rd(6'h20, '0, d); chk("R7 RA load bit5", d, 32'h10020);
    rd(6'h20, '0, d); chk("R7 read cleared", d, 32'h10000);
    wr(6'h00, 8'h02);

    // R8 event in the read cycle
    rd(6'h20, 7'b0100000, d); chk("R8 not in same read", d, 32'h0);
    rd(6'h20, '0, d); chk("R8 kept after read", d, 32'h40);
    pulseEvt(7'b1000000);
    rd(6'h20, 7'b1000000, d); chk("R8 repeat event", d, 32'h80);
    rd(6'h20, '0, d); chk("R8 still set", d, 32'h80);

    // R9 / R10 random mask and event traffic
    mMask = '0; mPend = '0;
    for (int i = 0; i < 60; i++) begin
      logic [7:0] v;
      logic [7:1] ev;
      v = 8'($urandom);
      if ($urandom % 2) begin wr(6'h24, v); mMask = mMask | v; end
      else begin wr(6'h28, v); mMask = mMask & ~v; end
      rd(6'h2C, '0, d); chk("R9 mask readback", d, {24'b0, mMask});
      ev = 7'($urandom) & 7'($urandom);
      pulseEvt(ev);
      mPend = mPend | {ev, 1'b0};
      chk("R10 irq", {31'b0, irq}, {31'b0, |(mPend & mMask)});
      if ($urandom % 4 == 0) begin
        rd(6'h20, '0, d); chk("R7 status flags", d, {24'b0, mPend});
        mPend = '0;
        chk("R10 irq after clear", {31'b0, irq}, 32'h0);
      end
    end
    rd(6'h20, '0, d);
    wr(6'h28, 8'hFF);
    wr(6'h24, 8'h01);

    // R6 wrap with slow base held high
    wr(6'h04, 8'd4);
    slowTick = 1'b1;
    wr(6'h00, 8'h05);
    idle(65535);
    chk("R6 no irq before wrap", {31'b0, irq}, 32'h0);
    rd(6'h10, '0, d); chk("R6 count at top", d, 32'hFFFF);
    chk("R6 R10 irq on wrap", {31'b0, irq}, 32'h1);
    slowTick = 1'b0;
    rd(6'h10, '0, d); chk("R6 wrapped to zero", d, 32'h0);
    rd(6'h20, '0, d); chk("R6 wrap flag", d, 32'h10001);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule